// File: doc/BRIEF.md
# Privileged Operation and Control Register Guard

This block sits in the decode stage. It screens each decoded request that touches privileged state before the request is allowed to execute. A request carries the following:

- an operation class;
- the current privilege level, where 0 is the most privileged;
- the length the decoder measured for the instruction;
- a proposed register value;
- a reserved-bit mask for the feature register and another for the machine-specific registers;
- a flag that restricts descriptor-table store instructions to privilege level 0.

In the same cycle, the guard answers a valid request with exactly one of two results: a general-protection fault, together with a cause code, or a permit.

The guard keeps a shadow copy of two control registers. The mode register holds the protection, paging, cache-disable and write-through-disable bits. The feature register holds feature enables. A permitted write to either register updates its shadow at the next clock edge. A faulting write leaves both shadows unchanged.

Top module: `priv_op_guard`

## Requirements
- R1: A valid request whose `insn_len` is greater than 15 faults with cause 1 (length). A length of exactly 15 does not cause a length fault.
- R2: A valid mode-register write (op class 1) whose value has the paging bit (bit 31) set and the protection bit (bit 0) clear faults with cause 3 (consistency).
- R3: A valid mode-register write whose value has the write-through-disable bit (bit 29) set and the cache-disable bit (bit 30) clear faults with cause 3 (consistency).
- R4: A valid feature-register write (op class 2) whose value has a 1 in any bit that is set in `feat_rsvd_mask` faults with cause 4 (reserved bit).
- R5: Four op classes require privilege level 0: privileged instruction (class 3), mode-register write (class 1), feature-register write (class 2) and machine-register write (class 5). Any of these at `priv_lvl` not equal to 0 faults with cause 2 (privilege).
- R6: A table-store instruction (class 4) at `priv_lvl` not equal to 0 faults with cause 2 when `store_lock` is 1. It is permitted when `store_lock` is 0. At level 0 it is always permitted.
- R7: A valid machine-register write (class 5) whose value has a 1 in any bit that is set in `mreg_rsvd_mask` faults with cause 4 (reserved bit).
- R8: When a request fails several checks, the length fault wins over every other fault. A privilege fault wins over a value fault (cause 3 or 4).
- R9: A valid request that fails no check asserts `permit` with cause 0, and so do plain operations (classes 0, 6 and 7) whose length is in range. With `req_valid` low, `fault` and `permit` are both 0 and the cause is 0.
- R10: A permitted write of class 1 or class 2 loads `wr_value` into the matching shadow at the next rising edge. A faulting request changes neither shadow.
- R11: While `rst_n` is low at a rising edge, the mode shadow becomes 0x6000_0010 and the feature shadow becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| op_class | input | 3 | Operation class: 0 plain, 1 mode write, 2 feature write, 3 privileged, 4 table store, 5 machine-register write |
| priv_lvl | input | 2 | Current privilege level |
| insn_len | input | 5 | Instruction length in bytes as measured by the decoder |
| wr_value | input | 32 | Proposed register value |
| feat_rsvd_mask | input | 32 | Reserved bits of the feature register |
| mreg_rsvd_mask | input | 32 | Reserved bits of the addressed machine register |
| store_lock | input | 1 | Table-store instructions need privilege level 0 |
| fault | output | 1 | General-protection fault for this request |
| permit | output | 1 | Request may execute |
| fault_cause | output | 3 | 0 none, 1 length, 2 privilege, 3 consistency, 4 reserved bit |
| mode_q | output | 32 | Mode register shadow |
| feat_q | output | 32 | Feature register shadow |

## Verification
Several properties are checked by assertions on every cycle:

- `fault` and `permit` never assert together;
- an over-long request always reports the length cause;
- a faulting cycle leaves both shadows stable;
- a permitted register write appears in its shadow one cycle later.

Other behaviour can only be shown by the bench scenarios, because each one depends on a particular combination of inputs. This covers the interaction of privilege level with the store lock, the exact boundary at 15 bytes, and the priority order among simultaneous failures. It also covers reserved-mask matches on single bits and the reset values of the shadows.

// File: rtl/guard_pkg.sv
// Shared types for the privileged operation guard.
// Assumes 3-bit operation class and cause codes; other class codes are plain.
package guard_pkg;

    typedef enum logic [2:0] {
        OPC_PLAIN   = 3'd0,
        OPC_MODE_WR = 3'd1,
        OPC_FEAT_WR = 3'd2,
        OPC_PRIV    = 3'd3,
        OPC_TBL_ST  = 3'd4,
        OPC_MREG_WR = 3'd5
    } op_class_e;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_LEN  = 3'd1,
        CAUSE_PRIV = 3'd2,
        CAUSE_CONS = 3'd3,
        CAUSE_RSVD = 3'd4
    } cause_e;

    // Operation classes that must run at privilege level 0 without exception.
    function automatic logic needs_level0(input logic [2:0] cls);
        return (cls == OPC_PRIV) || (cls == OPC_MODE_WR) ||
               (cls == OPC_FEAT_WR) || (cls == OPC_MREG_WR);
    endfunction

endpackage

// File: rtl/guard_len_check.sv
// Length check: flags an instruction whose measured length exceeds the cap.
// Assumes the length input is wide enough to present values above the cap.
module guard_len_check #(
    parameter int LEN_W   = 5,
    parameter int MAX_LEN = 15
) (
    input  logic [LEN_W-1:0] insn_len,
    output logic             too_long
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

    // Compare the decoder length against the cap.
    always_comb begin
        too_long = (insn_len > CAP);
    end
endmodule

// File: rtl/guard_priv_check.sv
// Privilege check: decides whether the operation class is allowed at the
// current level. Table stores are restricted only while the lock is set.
// Assumes level 0 is the most privileged level.
module guard_priv_check #(
    parameter int LVL_W = 2
) (
    input  logic [2:0]       op_class,
    input  logic [LVL_W-1:0] priv_lvl,
    input  logic             store_lock,
    output logic             priv_bad
);
    import guard_pkg::*;

    logic not_top;

    // Level-0 test and class-dependent restriction.
    always_comb begin
        not_top  = (priv_lvl != '0);
        priv_bad = 1'b0;
        if (not_top) begin
            if (needs_level0(op_class))
                priv_bad = 1'b1;
            else if (op_class == OPC_TBL_ST)
                priv_bad = store_lock;
        end
    end
endmodule

// File: rtl/guard_value_check.sv
// Value check: mode register cross-bit consistency and reserved-bit tests
// for feature and machine register writes. Classes without a value pass.
// Assumes bit positions are given by parameters and are below XLEN.
module guard_value_check #(
    parameter int XLEN   = 32,
    parameter int PE_BIT = 0,
    parameter int NW_BIT = 29,
    parameter int CD_BIT = 30,
    parameter int PG_BIT = 31
) (
    input  logic [2:0]      op_class,
    input  logic [XLEN-1:0] wr_value,
    input  logic [XLEN-1:0] feat_rsvd_mask,
    input  logic [XLEN-1:0] mreg_rsvd_mask,
    output logic            cons_bad,
    output logic            rsvd_bad
);
    import guard_pkg::*;

    logic page_wo_prot;
    logic wt_wo_cd;
    logic feat_hit;
    logic mreg_hit;

    // Per-rule detectors, independent of class.
    always_comb begin
        page_wo_prot = wr_value[PG_BIT] && !wr_value[PE_BIT];
        wt_wo_cd     = wr_value[NW_BIT] && !wr_value[CD_BIT];
        feat_hit     = |(wr_value & feat_rsvd_mask);
        mreg_hit     = |(wr_value & mreg_rsvd_mask);
    end

    // Select the rules that apply to this class.
    always_comb begin
        cons_bad = 1'b0;
        rsvd_bad = 1'b0;
        case (op_class)
            OPC_MODE_WR: cons_bad = page_wo_prot || wt_wo_cd;
            OPC_FEAT_WR: rsvd_bad = feat_hit;
            OPC_MREG_WR: rsvd_bad = mreg_hit;
            default: begin
                cons_bad = 1'b0;
                rsvd_bad = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/guard_shadow_regs.sv
// Shadow copies of the mode and feature registers, loaded on a permitted
// write. Synchronous active-low reset to parameter values.
module guard_shadow_regs #(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] MODE_RST = 32'h6000_0010,
    parameter logic [XLEN-1:0] FEAT_RST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_mode,
    input  logic            load_feat,
    input  logic [XLEN-1:0] wr_value,
    output logic [XLEN-1:0] mode_q,
    output logic [XLEN-1:0] feat_q
);
    // Mode register shadow.
    always_ff @(posedge clk) begin
        if (!rst_n)         mode_q <= MODE_RST;
        else if (load_mode) mode_q <= wr_value;
    end

    // Feature register shadow.
    always_ff @(posedge clk) begin
        if (!rst_n)         feat_q <= FEAT_RST;
        else if (load_feat) feat_q <= wr_value;
    end

    // R10: the two loads come from one decoded class and never coincide.
    a_r10_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_mode && load_feat));
endmodule

// File: rtl/priv_op_guard.sv
// Privileged operation guard: combines the length, privilege and value
// checks with a fixed priority, answers each valid request with a fault
// or a permit in the same cycle, and keeps the control register shadows.
// Assumes a request is held for one cycle and the result is consumed in it.
module priv_op_guard #(
    parameter int              XLEN     = 32,
    parameter int              LEN_W    = 5,
    parameter int              LVL_W    = 2,
    parameter int              MAX_LEN  = 15,
    parameter logic [XLEN-1:0] MODE_RST = 32'h6000_0010,
    parameter logic [XLEN-1:0] FEAT_RST = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       op_class,
    input  logic [LVL_W-1:0] priv_lvl,
    input  logic [LEN_W-1:0] insn_len,
    input  logic [XLEN-1:0]  wr_value,
    input  logic [XLEN-1:0]  feat_rsvd_mask,
    input  logic [XLEN-1:0]  mreg_rsvd_mask,
    input  logic             store_lock,
    output logic             fault,
    output logic             permit,
    output logic [2:0]       fault_cause,
    output logic [XLEN-1:0]  mode_q,
    output logic [XLEN-1:0]  feat_q
);
    import guard_pkg::*;

    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

    logic   too_long;
    logic   priv_bad;
    logic   cons_bad;
    logic   rsvd_bad;
    cause_e cause;
    logic   load_mode;
    logic   load_feat;

    guard_len_check #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_len (
        .insn_len (insn_len),
        .too_long (too_long)
    );

    guard_priv_check #(.LVL_W(LVL_W)) u_priv (
        .op_class   (op_class),
        .priv_lvl   (priv_lvl),
        .store_lock (store_lock),
        .priv_bad   (priv_bad)
    );

    guard_value_check #(.XLEN(XLEN)) u_val (
        .op_class       (op_class),
        .wr_value       (wr_value),
        .feat_rsvd_mask (feat_rsvd_mask),
        .mreg_rsvd_mask (mreg_rsvd_mask),
        .cons_bad       (cons_bad),
        .rsvd_bad       (rsvd_bad)
    );

    // Priority arbitration: length, then privilege, then value rules.
    always_comb begin
        cause = CAUSE_NONE;
        if (req_valid) begin
            if (too_long)      cause = CAUSE_LEN;
            else if (priv_bad) cause = CAUSE_PRIV;
            else if (cons_bad) cause = CAUSE_CONS;
            else if (rsvd_bad) cause = CAUSE_RSVD;
        end
    end

    // Result outputs and shadow load strobes.
    always_comb begin
        fault       = req_valid && (cause != CAUSE_NONE);
        permit      = req_valid && (cause == CAUSE_NONE);
        fault_cause = cause;
        load_mode   = permit && (op_class == OPC_MODE_WR);
        load_feat   = permit && (op_class == OPC_FEAT_WR);
    end

    guard_shadow_regs #(.XLEN(XLEN), .MODE_RST(MODE_RST), .FEAT_RST(FEAT_RST)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_mode (load_mode),
        .load_feat (load_feat),
        .wr_value  (wr_value),
        .mode_q    (mode_q),
        .feat_q    (feat_q)
    );

    // R9: fault and permit are mutually exclusive.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault && permit));

    // R9: no result without a request.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!fault && !permit && fault_cause == 3'd0));

    // R1, R8: an over-long request always reports the length cause.
    a_r1_len_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && insn_len > CAP) |-> (fault && fault_cause == 3'd1));

    // R5: level-0 classes at a lower level never get a permit.
    a_r5_no_permit_low: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && priv_lvl != '0 && needs_level0(op_class)) |-> !permit);

    // R10: a faulting cycle leaves both shadows unchanged.
    a_r10_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> ($stable(mode_q) && $stable(feat_q)));

    // R10: a permitted mode write shows up in the shadow next cycle.
    a_r10_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        (permit && op_class == OPC_MODE_WR) |=> (mode_q == $past(wr_value)));
endmodule

// File: tb/priv_op_guard_bench.sv
// Bench for the privileged operation guard: directed corners then seeded
// random requests, checked against a behavioural model built from the brief.
module priv_op_guard_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  op_class;
    logic [1:0]  priv_lvl;
    logic [4:0]  insn_len;
    logic [31:0] wr_value;
    logic [31:0] feat_rsvd_mask;
    logic [31:0] mreg_rsvd_mask;
    logic        store_lock;
    logic        fault;
    logic        permit;
    logic [2:0]  fault_cause;
    logic [31:0] mode_q;
    logic [31:0] feat_q;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    logic [31:0] m_mode;
    logic [31:0] m_feat;

    priv_op_guard u_priv_op_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_class(op_class),
        .priv_lvl(priv_lvl), .insn_len(insn_len), .wr_value(wr_value),
        .feat_rsvd_mask(feat_rsvd_mask), .mreg_rsvd_mask(mreg_rsvd_mask),
        .store_lock(store_lock), .fault(fault), .permit(permit),
        .fault_cause(fault_cause), .mode_q(mode_q), .feat_q(feat_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected cause from the requirements.
    function automatic logic [2:0] exp_cause(input logic v, input logic [2:0] c,
            input logic [1:0] l, input logic [4:0] n, input logic [31:0] w,
            input logic [31:0] fm, input logic [31:0] mm, input logic lk);
        logic lvl0cls;
        if (!v) return 3'd0;
        if (n > 5'd15) return 3'd1;
        lvl0cls = (c == 3'd1) || (c == 3'd2) || (c == 3'd3) || (c == 3'd5);
        if (l != 2'd0 && (lvl0cls || (c == 3'd4 && lk))) return 3'd2;
        if (c == 3'd1 && ((w[31] && !w[0]) || (w[29] && !w[30]))) return 3'd3;
        if (c == 3'd2 && (w & fm) != 0) return 3'd4;
        if (c == 3'd5 && (w & mm) != 0) return 3'd4;
        return 3'd0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request: drive at negedge, check result, then check shadows after the edge.
    task automatic step(input string tag, input logic v, input logic [2:0] c,
            input logic [1:0] l, input logic [4:0] n, input logic [31:0] w,
            input logic [31:0] fm, input logic [31:0] mm, input logic lk);
        logic [2:0] ec;
        @(negedge clk);
        req_valid = v; op_class = c; priv_lvl = l; insn_len = n;
        wr_value = w; feat_rsvd_mask = fm; mreg_rsvd_mask = mm; store_lock = lk;
        #1;
        ec = exp_cause(v, c, l, n, w, fm, mm, lk);
        check({tag, " cause"}, {29'd0, fault_cause}, {29'd0, ec});
        check({tag, " fault/permit"}, {30'd0, fault, permit},
              {30'd0, v && ec != 0, v && ec == 0});
        if (v && ec == 0 && c == 3'd1) m_mode = w;
        if (v && ec == 0 && c == 3'd2) m_feat = w;
        @(posedge clk); #1;
        check({tag, " R10 mode shadow"}, mode_q, m_mode);
        check({tag, " R10 feat shadow"}, feat_q, m_feat);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; req_valid = 1'b0; op_class = 3'd0; priv_lvl = 2'd0;
        insn_len = 5'd1; wr_value = '0; feat_rsvd_mask = '0; mreg_rsvd_mask = '0;
        store_lock = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R11 mode reset", mode_q, 32'h6000_0010);
        check("R11 feat reset", feat_q, 32'h0);
        m_mode = 32'h6000_0010; m_feat = 32'h0;
        @(negedge clk); rst_n = 1'b1;

        step("R9 idle",            1'b0, 3'd1, 2'd0, 5'd4, 32'h8000_0001, 0, 0, 0);
        step("R9 plain",           1'b1, 3'd0, 2'd3, 5'd4, 32'h0, 0, 0, 1);
        step("R1 len 15 ok",       1'b1, 3'd6, 2'd0, 5'd15, 32'h0, 0, 0, 0);
        step("R1 len 16",          1'b1, 3'd0, 2'd0, 5'd16, 32'h0, 0, 0, 0);
        step("R1 len 31",          1'b1, 3'd7, 2'd0, 5'd31, 32'h0, 0, 0, 0);
        step("R2 page no prot",    1'b1, 3'd1, 2'd0, 5'd3, 32'hC000_0000, 0, 0, 0);
        step("R3 wt no cd",        1'b1, 3'd1, 2'd0, 5'd3, 32'h2000_0001, 0, 0, 0);
        step("R10 mode ok",        1'b1, 3'd1, 2'd0, 5'd3, 32'hE000_0001, 0, 0, 0);
        step("R4 feat rsvd",       1'b1, 3'd2, 2'd0, 5'd3, 32'h0000_0400, 32'h0000_0400, 0, 0);
        step("R10 feat ok",        1'b1, 3'd2, 2'd0, 5'd3, 32'h0000_0200, 32'h0000_0400, 0, 0);
        step("R5 priv lvl3",       1'b1, 3'd3, 2'd3, 5'd2, 32'h0, 0, 0, 0);
        step("R5 priv lvl0",       1'b1, 3'd3, 2'd0, 5'd2, 32'h0, 0, 0, 0);
        step("R5 feat wr lvl1",    1'b1, 3'd2, 2'd1, 5'd2, 32'h1, 0, 0, 0);
        step("R6 store unlock",    1'b1, 3'd4, 2'd3, 5'd3, 32'h0, 0, 0, 0);
        step("R6 store lock",      1'b1, 3'd4, 2'd3, 5'd3, 32'h0, 0, 0, 1);
        step("R6 store lvl0 lock", 1'b1, 3'd4, 2'd0, 5'd3, 32'h0, 0, 0, 1);
        step("R7 mreg rsvd",       1'b1, 3'd5, 2'd0, 5'd3, 32'h8000_0000, 0, 32'h8000_0000, 0);
        step("R7 mreg ok",         1'b1, 3'd5, 2'd0, 5'd3, 32'h7FFF_FFFF, 0, 32'h8000_0000, 0);
        step("R8 len over priv",   1'b1, 3'd3, 2'd2, 5'd20, 32'h0, 0, 0, 0);
        step("R8 priv over cons",  1'b1, 3'd1, 2'd1, 5'd3, 32'h8000_0000, 0, 0, 0);
        step("R8 priv over rsvd",  1'b1, 3'd5, 2'd2, 5'd3, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, 0);

        for (int i = 0; i < 600; i++) begin
            logic [4:0]  n;
            logic [31:0] w;
            logic [31:0] fm;
            logic [31:0] mm;
            n  = 5'($urandom);
            if ($urandom % 4 != 0) n = n % 16;
            w  = $urandom;
            fm = ($urandom % 2 == 0) ? 32'h0 : (32'h1 << ($urandom % 32));
            mm = ($urandom % 2 == 0) ? 32'h0 : $urandom;
            step("R8 random", 1'($urandom % 8 != 0), 3'($urandom), 2'($urandom),
                 n, w, fm, mm, 1'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule